// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block generates the low address bits for each beat of a four-beat memory burst. A start strobe captures the starting low address and resets the internal beat count. Each following cycle with the active-low advance input driven low moves the burst one beat forward. The upper address bits are not handled here. They pass around the block unchanged.

A mode input picks the order in which the beats are visited. In linear order the address is the start value plus the beat count, wrapping modulo four. In interleaved order the address is the start value XORed with the beat count. Once the fourth beat has been reached, continued advancing wraps the count and returns the address to the loaded start. The counter width is a parameter and defaults to two bits. Outputs are registered state, except for a final combinational mux that the mode input controls.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released with no start or advance, `burst_addr_o` and `beat_o` are both 0.
- R2: In the cycle after a clock edge where `start_i` is 1, `beat_o` is 0 and `burst_addr_o` equals the `start_addr_i` value sampled at that edge, in either mode.
- R3: At an edge with `start_i` = 0 and `adv_n_i` = 0, `beat_o` increments by one, modulo 4.
- R4: At an edge with `start_i` = 0 and `adv_n_i` = 1, `beat_o` and `burst_addr_o` keep their values.
- R5: With `mode_i` = 0 (linear order), `burst_addr_o` = (start + beat) mod 4. For example, start 01 gives 01, 10, 11, 00.
- R6: With `mode_i` = 1 (interleaved order), `burst_addr_o` = start XOR beat. For example, start 10 gives 10, 11, 00, 01, and start 11 gives 11, 10, 01, 00.
- R7: An advance taken at beat 3 returns `beat_o` to 0 and `burst_addr_o` to the loaded start address.
- R8: When `start_i` = 1 and `adv_n_i` = 0 at the same edge, the load wins. The result is beat 0 at the new start address, with no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Burst start strobe; loads the start address |
| start_addr_i | input | CNT_W | Low address bits captured on a start |
| adv_n_i | input | 1 | Active-low advance enable |
| mode_i | input | 1 | Beat order: 0 = linear, 1 = interleaved |
| burst_addr_o | output | CNT_W | Low address bits for the current beat |
| beat_o | output | CNT_W | Beat index since the last start, 0 to 3 |

## Verification
The bench runs every start value in both modes through a full burst and on into a fifth advance. A design that saturated at beat 3, or that reloaded zero instead of the captured start, would show the wrong address after the wrap. Bursts that start at 01 and 11 in interleaved order catch a design that adds where it should XOR, because those are the starts where the two orders disagree. Cycles with `adv_n_i` held high are placed in the middle of bursts, so a counter that ignored the enable, or read its polarity inverted, would step when it should hold. Loads asserted together with an advance expose a design that gives priority to the advance, which would come out on beat 1 instead of beat 0.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

endpackage

// File: rtl/burst_rst_sync.sv
module burst_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             adv_n_i,
  output logic [CNT_W-1:0] base_o,
  output logic [CNT_W-1:0] beat_o
);

  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             ctr_en;

  // A load takes priority over an advance.
  assign ctr_en = load_i | ~adv_n_i;

  always_comb begin
    base_d = base_q;
    beat_d = beat_q;
    if (load_i) begin
      base_d = load_val_i;
      beat_d = '0;
    end else if (!adv_n_i) begin
      beat_d = CNT_W'(beat_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (ctr_en) begin
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign base_o = base_q;
  assign beat_o = beat_q;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (base_q == $past(load_val_i)));

  a_r8_load_first: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (beat_q == '0));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n_i) |=> (beat_q == CNT_W'($past(beat_q) + 1'b1)));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n_i) |=> ($stable(beat_q) && $stable(base_q)));

endmodule

// File: rtl/burst_addr_form.sv
module burst_addr_form
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] base_i,
  input  logic [CNT_W-1:0] beat_i,
  input  burst_order_e     order_i,
  output logic [CNT_W-1:0] addr_o
);

  logic [CNT_W-1:0] lin_addr;
  logic [CNT_W-1:0] ilv_addr;

  // Linear order: the sum wraps because it is truncated to CNT_W bits.
  assign lin_addr = CNT_W'(base_i + beat_i);

  // Interleaved order: each bit of the start is flipped by the matching beat bit.
  for (genvar b = 0; b < CNT_W; b++) begin : g_ilv_bit
    assign ilv_addr[b] = base_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORDER_INTERLEAVE: addr_o = ilv_addr;
      default:          addr_o = lin_addr;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] start_addr_i,
  input  logic             adv_n_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] burst_addr_o,
  output logic [CNT_W-1:0] beat_o
);

  localparam int BEATS = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BEATS - 1);

  logic             core_rst_n;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] beat;
  burst_order_e     order;

  assign order = burst_order_e'(mode_i);

  burst_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (core_rst_n)
  );

  burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .load_i     (start_i),
    .load_val_i (start_addr_i),
    .adv_n_i    (adv_n_i),
    .base_o     (base),
    .beat_o     (beat)
  );

  burst_addr_form #(.CNT_W(CNT_W)) u_form (
    .base_i  (base),
    .beat_i  (beat),
    .order_i (order),
    .addr_o  (burst_addr_o)
  );

  assign beat_o = beat;

  // R5: in linear order each step moves the address up by one.
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!start_i && !adv_n_i && !mode_i) ##1 !mode_i
      |-> (burst_addr_o == CNT_W'($past(burst_addr_o) + 1'b1)));

  // R6: in interleaved order the first step flips only bit 0.
  a_r6_ilv_first: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!start_i && !adv_n_i && mode_i && beat_o == '0) ##1 mode_i
      |-> (burst_addr_o == ($past(burst_addr_o) ^ CNT_W'(1))));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!start_i && !adv_n_i && beat_o == LAST_BEAT) |=> (beat_o == '0));

  a_r2_first_addr: assert property (@(posedge clk) disable iff (!core_rst_n)
    start_i |=> (burst_addr_o == $past(start_addr_i)));

endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] start_addr_i;
  logic       adv_n_i;
  logic       mode_i;
  logic [1:0] burst_addr_o;
  logic [1:0] beat_o;

  typedef struct {
    logic [1:0] addr;
    logic [1:0] beat;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp  = 0;
  int   n_bad  = 0;
  bit   done   = 0;

  logic [1:0] m_base = 2'd0;
  logic [1:0] m_beat = 2'd0;

  burst_addr_seq #(.CNT_W(2)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .adv_n_i      (adv_n_i),
    .mode_i       (mode_i),
    .burst_addr_o (burst_addr_o),
    .beat_o       (beat_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic st, input logic [1:0] a, input logic adv_n, input logic md);
    exp_t  e;
    string t;
    @(negedge clk);
    start_i      = st;
    start_addr_i = a;
    adv_n_i      = adv_n;
    mode_i       = md;
    if (st) begin
      t = adv_n ? "R2" : "R8";
      m_base = a;
      m_beat = 2'd0;
    end else if (!adv_n) begin
      m_beat = m_beat + 2'd1;
      t = (m_beat == 2'd0) ? "R7" : (md ? "R3/R6" : "R3/R5");
    end else begin
      t = "R4";
    end
    e.addr = md ? (m_base ^ m_beat) : (m_base + m_beat);
    e.beat = m_beat;
    e.tag  = t;
    exp_q.push_back(e);
  endtask

  // Monitor: compares once per cycle, shortly after the rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (burst_addr_o !== e.addr || beat_o !== e.beat) begin
          n_bad++;
          $display("FAIL %s: addr=%b beat=%0d expected addr=%b beat=%0d",
                   e.tag, burst_addr_o, beat_o, e.addr, e.beat);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; start_addr_i = 2'd0; adv_n_i = 1'b1; mode_i = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    n_cmp++;
    if (burst_addr_o !== 2'd0 || beat_o !== 2'd0) begin
      n_bad++;
      $display("FAIL R1: addr=%b beat=%0d expected addr=00 beat=0", burst_addr_o, beat_o);
    end
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b0, 2'd3, 1'b1, 1'b0);  // R1 idle after release

    // R5/R6/R7: every start, both orders, four advances plus one wrap.
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 4; s++) begin
        step(1'b1, 2'(s), 1'b1, 1'(md));
        for (int k = 0; k < 5; k++) step(1'b0, 2'(~s), 1'b0, 1'(md));
      end
    end

    // R4: holds placed mid-burst.
    step(1'b1, 2'd1, 1'b1, 1'b1);
    step(1'b0, 2'd0, 1'b0, 1'b1);
    step(1'b0, 2'd2, 1'b1, 1'b1);
    step(1'b0, 2'd3, 1'b1, 1'b1);
    step(1'b0, 2'd0, 1'b0, 1'b1);
    step(1'b0, 2'd0, 1'b1, 1'b0);

    // R8: a reload with an advance in the same cycle, mid-burst.
    step(1'b1, 2'd2, 1'b0, 1'b0);
    step(1'b0, 2'd0, 1'b0, 1'b0);
    step(1'b1, 2'd3, 1'b0, 1'b0);
    step(1'b0, 2'd0, 1'b0, 1'b0);
    step(1'b1, 2'd1, 1'b0, 1'b1);
    step(1'b0, 2'd0, 1'b0, 1'b1);

    // R2: back-to-back loads.
    step(1'b1, 2'd0, 1'b1, 1'b1);
    step(1'b1, 2'd3, 1'b1, 1'b1);

    @(negedge clk);
    start_i = 1'b0; adv_n_i = 1'b1;
    repeat (3) @(posedge clk);
    #5;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule